// File: doc/BRIEF.md
# Flow-through synchronous burst SRAM

This block is a behavioural model of a synchronous static RAM with a flow-through read path. Address, control and write data are all captured on the rising clock edge. Read data for the captured address appears in the cycle that follows that edge, with no extra output register. A drive flag stands in for the high-impedance state of a shared data bus. Storage depth is a parameter; each word holds four 8-bit lanes.

An access begins on one of two active-low start strobes, "host start" or "cache start", and each follows its own rules. The three chip selects are captured only when an access begins. The two lowest address bits then step through a four-beat burst under an active-low advance strobe. The burst order is chosen with a mode input: linear counting or exclusive-or interleaving. A low-power doze input holds the contents and blocks all accesses while it is asserted and for a short recovery after it is released.

Top module: `burst_sram_ft`

## Requirements
- R1: While reset is asserted and after it is released, the device is deselected and `rdDrive` stays low until an access begins.
- R2: An access selects the device only when `selN` is 0, `selHi` is 1 and `selLoN` is 0 at its start. In every other case the device is deselected: `rdDrive` stays 0 and no write takes place until the next start.
- R3: The selects are ignored on edges where neither start strobe is 0. The selection made at the last start is kept.
- R4: `hostStartN` low is ignored when `selN` is 1. With `ctlStartN` high, the current burst continues unchanged.
- R5: When both start strobes are low and `selN` is 0, the host start wins. That edge is a read, and the write controls have no effect on it.
- R6: `globalWrN` = 0 writes all four lanes at the current address, whatever `laneWrN` holds.
- R7: With `globalWrN` = 1 and `byteWrEnN` = 0, each 0 bit i of `laneWrN` writes lane i, which is bits 8i+7 to 8i. The other lanes keep their contents.
- R8: With `globalWrN` = 1 and `byteWrEnN` = 1, no lane is written, and a cache start becomes a read.
- R9: After an edge that performs no write, `rdData` carries the word at the captured burst address in that same cycle. `rdDrive` is 1 if the device is selected and `outEnN` is 0. `outEnN` acts on `rdDrive` without waiting for a clock.
- R10: Each edge with `advN` = 0 and no start moves the burst count up by one, modulo 4, and `advN` = 1 keeps it. The low two address bits are start+count when `burstLinear` = 1 and start XOR count when it is 0. The upper address bits are held.
- R11: A burst begun by the host start reads on its first edge. On a following edge with `advN` = 1, the write controls write to that same start address.
- R12: While `doze` = 1, and for 2 edges after it returns to 0, no access is accepted, the device is deselected and stored data is kept. The third edge after release accepts an access.
- R13: In the cycle after an edge that writes, `rdDrive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| hostStartN | input | 1 | Host start strobe, active low, blocked by `selN` |
| ctlStartN | input | 1 | Cache start strobe, active low |
| advN | input | 1 | Burst advance, active low |
| selN | input | 1 | Primary chip select, active low |
| selHi | input | 1 | Chip select, active high |
| selLoN | input | 1 | Chip select, active low |
| addr | input | ADDR_W | Word address |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrEnN | input | 1 | Enables the lane write controls, active low |
| laneWrN | input | 4 | Per-lane write controls, active low |
| outEnN | input | 1 | Output enable, active low, asynchronous |
| burstLinear | input | 1 | 1 = linear burst order, 0 = interleaved |
| doze | input | 1 | Low-power hold request |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, 0 when not driving |
| rdDrive | output | 1 | 1 when the data bus would be driven |

## Verification
Read data and drive state are due in the same cycle as the edge that captures the address or the advance, because there is no output register. Writes take effect on the edge itself, so a read started on the next edge shows them. The doze recovery spans exactly two edges after release, so the first accepted access falls on the third edge. The bench changes inputs on the falling edge and checks outputs on the next falling edge, which is one capturing edge later. The only check made without a clock is the asynchronous output-enable check, taken a short delay after the enable changes.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANES   = 4;
  localparam int LANE_W  = 8;
  localparam int DATA_W  = LANES * LANE_W;
  localparam int BURST_W = 2;

  // Strobes from control to datapath for the current edge / cycle
  typedef struct packed {
    logic             wrEn;      // write at wrAddr on this edge
    logic [LANES-1:0] laneMask;  // lanes written
    logic             outOn;     // selected and last edge was not a write
  } memStrobe_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostStartN,
  input  logic              ctlStartN,
  input  logic              advN,
  input  logic              selN,
  input  logic              selHi,
  input  logic              selLoN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              burstLinear,
  input  logic              doze,
  output memStrobe_t        strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int WAKE_CYC = 2;
  localparam int WAKE_W   = $clog2(WAKE_CYC + 1);

  logic              selQ, lastWrQ;
  logic [ADDR_W-1:0] baseQ;
  logic [BURST_W-1:0] cntQ;
  logic [WAKE_W-1:0] wakeCnt;

  logic              blocked, hostGo, ctlGo, selNow;
  logic              nextSel, wrEnC;
  logic [ADDR_W-1:0] nextBase;
  logic [BURST_W-1:0] nextCnt;
  logic [LANES-1:0]  laneReq;

  function automatic logic [BURST_W-1:0] burstLow(input logic [BURST_W-1:0] b,
                                                  input logic [BURST_W-1:0] c,
                                                  input logic lin);
    return lin ? b + c : b ^ c;
  endfunction

  assign blocked = doze || (wakeCnt != '0);
  assign hostGo  = !blocked && !hostStartN && !selN;
  assign ctlGo   = !blocked && !ctlStartN && !hostGo;
  assign selNow  = !selN && selHi && !selLoN;
  assign laneReq = !globalWrN ? '1 : (!byteWrEnN ? ~laneWrN : '0);

  always_comb begin
    nextSel  = selQ;
    nextBase = baseQ;
    nextCnt  = cntQ;
    wrEnC    = 1'b0;
    if (blocked) begin
      nextSel = 1'b0;
    end else if (hostGo || ctlGo) begin
      nextSel  = selNow;
      nextBase = addr;
      nextCnt  = '0;
      wrEnC    = ctlGo && selNow && (laneReq != '0);
    end else if (selQ) begin
      if (!advN) nextCnt = cntQ + 1'b1;
      wrEnC = (laneReq != '0);
    end
  end

  assign wrAddr  = {nextBase[ADDR_W-1:BURST_W], burstLow(nextBase[BURST_W-1:0], nextCnt, burstLinear)};
  assign curAddr = {baseQ[ADDR_W-1:BURST_W], burstLow(baseQ[BURST_W-1:0], cntQ, burstLinear)};

  assign strobe.wrEn     = wrEnC;
  assign strobe.laneMask = laneReq;
  assign strobe.outOn    = selQ && !lastWrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ    <= 1'b0;
      lastWrQ <= 1'b0;
      baseQ   <= '0;
      cntQ    <= '0;
      wakeCnt <= '0;
    end else begin
      selQ    <= nextSel;
      lastWrQ <= wrEnC;
      baseQ   <= nextBase;
      cntQ    <= nextCnt;
      if (doze)                wakeCnt <= WAKE_W'(WAKE_CYC);
      else if (wakeCnt != '0)  wakeCnt <= wakeCnt - 1'b1;
    end
  end

  // R1: reset leaves the device deselected
  a_r1_reset_deselect: assert property (@(posedge clk) !rstN |=> !strobe.outOn);

  // R3: without a start the selection is kept
  a_r3_sel_hold: assert property (@(posedge clk) disable iff (!rstN)
    (hostStartN && ctlStartN && !doze && wakeCnt == '0) |=> $stable(selQ));

  // R10: burst never leaves its four-word block
  a_r10_block_hold: assert property (@(posedge clk) disable iff (!rstN)
    (hostStartN && ctlStartN && !doze && wakeCnt == '0 && selQ)
      |=> $stable(curAddr[ADDR_W-1:BURST_W]));

  // R12: doze turns the outputs off on the next cycle
  a_r12_doze_off: assert property (@(posedge clk) disable iff (!rstN)
    doze |=> !strobe.outOn);
endmodule

// File: rtl/burst_sram_dp.sv
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              outEnN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive
);
  logic [DATA_W-1:0] rawRd;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (strobe.wrEn && strobe.laneMask[g])
        laneMem[wrAddr] <= wrData[g*LANE_W +: LANE_W];
    end
    assign rawRd[g*LANE_W +: LANE_W] = laneMem[curAddr];
  end

  assign rdDrive = strobe.outOn && !outEnN;
  assign rdData  = rdDrive ? rawRd : '0;

  // R13: the cycle after a write never drives the bus
  a_r13_write_hiz: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> !rdDrive);
endmodule

// File: rtl/burst_sram_ft.sv
module burst_sram_ft
  import burst_sram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostStartN,
  input  logic              ctlStartN,
  input  logic              advN,
  input  logic              selN,
  input  logic              selHi,
  input  logic              selLoN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              outEnN,
  input  logic              burstLinear,
  input  logic              doze,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive
);
  memStrobe_t        strobe;
  logic [ADDR_W-1:0] wrAddr, curAddr;

  burst_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostStartN(hostStartN), .ctlStartN(ctlStartN),
    .advN(advN), .selN(selN), .selHi(selHi), .selLoN(selLoN), .addr(addr),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .burstLinear(burstLinear), .doze(doze),
    .strobe(strobe), .wrAddr(wrAddr), .curAddr(curAddr)
  );

  burst_sram_dp #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .curAddr(curAddr), .wrData(wrData), .outEnN(outEnN),
    .rdData(rdData), .rdDrive(rdDrive)
  );
endmodule

// File: tb/burst_sram_ft_bench.sv
module burst_sram_ft_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk, rstN, hostStartN, ctlStartN, advN, selN, selHi, selLoN;
  logic [AW-1:0] addr;
  logic globalWrN, byteWrEnN, outEnN, burstLinear, doze;
  logic [3:0] laneWrN;
  logic [31:0] wrData, rdData;
  logic rdDrive;

  logic [31:0] model [0:95];
  int testsRun = 0;
  int testsFailed = 0;

  burst_sram_ft #(.DEPTH(256)) u_burst_sram_ft (
    .clk(clk), .rstN(rstN), .hostStartN(hostStartN), .ctlStartN(ctlStartN),
    .advN(advN), .selN(selN), .selHi(selHi), .selLoN(selLoN), .addr(addr),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .outEnN(outEnN), .burstLinear(burstLinear), .doze(doze),
    .wrData(wrData), .rdData(rdData), .rdDrive(rdDrive)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pat(input int a);
    logic [7:0] v;
    v = a[7:0];
    return {v ^ 8'h3C, ~v, v + 8'h11, 8'hC3};
  endfunction

  task automatic idle();
    hostStartN = 1; ctlStartN = 1; advN = 1;
    selN = 0; selHi = 1; selLoN = 0;
    globalWrN = 1; byteWrEnN = 1; laneWrN = 4'hF;
    outEnN = 0; doze = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readAt(input int a);
    idle();
    ctlStartN = 0; addr = AW'(a);
    tick();
    ctlStartN = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    testsRun++; testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [31:0] m32, exp;
    int ea;
    idle(); rstN = 0; addr = '0; wrData = '0; burstLinear = 1;
    repeat (3) @(negedge clk);
    chk(!rdDrive, "R1 off during reset", {31'd0, rdDrive}, 32'd0);
    rstN = 1;
    tick();
    chk(!rdDrive, "R1 off after reset", {31'd0, rdDrive}, 32'd0);

    // Fill 0..95 with cache-start global writes
    for (int a = 0; a < 96; a++) begin
      ctlStartN = 0; addr = AW'(a); globalWrN = 0; wrData = pat(a);
      tick();
      model[a] = pat(a);
      if (a < 4) chk(!rdDrive, "R13 off after write", {31'd0, rdDrive}, 32'd0);
    end
    idle();

    // Burst sweep: both orders, all start offsets in two blocks
    for (int lin = 0; lin < 2; lin++) begin
      burstLinear = lin[0];
      for (int b = 8; b < 16; b++) begin
        hostStartN = 0; addr = AW'(b);
        tick();
        hostStartN = 1;
        chk(rdDrive && rdData == model[b], "R9 flow-through first beat", rdData, model[b]);
        ea = b;
        for (int k = 1; k < 4; k++) begin
          advN = 0;
          tick();
          ea = (b & ~3) | ((lin != 0 ? (b + k) : (b ^ k)) & 3);
          chk(rdDrive && rdData == model[ea], "R10 burst beat", rdData, model[ea]);
        end
        advN = 1;
        tick();
        chk(rdDrive && rdData == model[ea], "R10 suspend holds", rdData, model[ea]);
      end
    end
    burstLinear = 1;

    // R6: global write overrides lane controls
    idle();
    ctlStartN = 0; addr = 30; globalWrN = 0; byteWrEnN = 0; laneWrN = 4'hF; wrData = 32'hDEAD_BEEF;
    tick();
    model[30] = 32'hDEAD_BEEF;
    readAt(30);
    chk(rdDrive && rdData == model[30], "R6 all lanes written", rdData, model[30]);

    // R7: every lane pattern
    for (int m = 0; m < 16; m++) begin
      idle();
      ctlStartN = 0; addr = AW'(40 + m); byteWrEnN = 0; laneWrN = ~m[3:0]; wrData = 32'hFFFF_FFFF;
      tick();
      m32 = {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
      model[40 + m] = (model[40 + m] & ~m32) | m32;
      readAt(40 + m);
      chk(rdDrive && rdData == model[40 + m], "R7 lane write", rdData, model[40 + m]);
    end

    // R8: no write enables -> read
    idle();
    ctlStartN = 0; addr = 50; laneWrN = 4'h0; wrData = 32'h0;
    tick();
    chk(rdDrive && rdData == model[50], "R8 no write", rdData, model[50]);

    // R11: host start reads, then writes on the following edge
    idle();
    hostStartN = 0; addr = 70; globalWrN = 0; wrData = 32'h1111_1111;
    tick();
    chk(rdDrive && rdData == model[70], "R11 first edge is read", rdData, model[70]);
    hostStartN = 1; advN = 1; globalWrN = 0; wrData = 32'h5A5A_0F0F;
    tick();
    model[70] = 32'h5A5A_0F0F;
    chk(!rdDrive, "R13 off after write", {31'd0, rdDrive}, 32'd0);
    globalWrN = 1;
    tick();
    chk(rdDrive && rdData == model[70], "R11 write at start address", rdData, model[70]);

    // R5: both strobes -> host wins, read only
    idle();
    hostStartN = 0; ctlStartN = 0; addr = 71; globalWrN = 0; wrData = 32'h0;
    tick();
    chk(rdDrive && rdData == model[71], "R5 host precedence", rdData, model[71]);

    // R4: host start blocked by selN
    idle();
    selN = 1; hostStartN = 0; addr = 72;
    tick();
    chk(rdDrive && rdData == model[71], "R4 host start ignored", rdData, model[71]);

    // R2: deselecting starts
    idle();
    selN = 1; ctlStartN = 0; addr = 72;
    tick();
    chk(!rdDrive, "R2 selN high deselects", {31'd0, rdDrive}, 32'd0);
    idle();
    ctlStartN = 1; globalWrN = 0; wrData = 32'h0; advN = 0;
    tick();
    readAt(72);
    chk(rdDrive && rdData == model[72], "R2 no write when deselected", rdData, model[72]);
    idle();
    selHi = 0; ctlStartN = 0; addr = 72;
    tick();
    chk(!rdDrive, "R2 selHi low deselects", {31'd0, rdDrive}, 32'd0);
    idle();
    selLoN = 1; ctlStartN = 0; addr = 72;
    tick();
    chk(!rdDrive, "R2 selLoN high deselects", {31'd0, rdDrive}, 32'd0);

    // R3: selects ignored mid-burst
    readAt(73);
    chk(rdDrive && rdData == model[73], "R3 start read", rdData, model[73]);
    selN = 1; selHi = 0; selLoN = 1; advN = 0;
    tick();
    chk(rdDrive && rdData == model[74], "R3 selection kept", rdData, model[74]);
    idle();

    // R9: asynchronous output enable
    outEnN = 1; #1;
    chk(!rdDrive, "R9 outEnN high", {31'd0, rdDrive}, 32'd0);
    outEnN = 0; #1;
    chk(rdDrive, "R9 outEnN low", {31'd0, rdDrive}, 32'd1);
    @(negedge clk);

    // R12: doze and recovery
    idle();
    doze = 1; ctlStartN = 0; addr = 80; globalWrN = 0; wrData = 32'h0;
    tick();
    chk(!rdDrive, "R12 off in doze", {31'd0, rdDrive}, 32'd0);
    tick(); tick();
    doze = 0;
    tick();
    chk(!rdDrive, "R12 recovery edge 1", {31'd0, rdDrive}, 32'd0);
    tick();
    chk(!rdDrive, "R12 recovery edge 2", {31'd0, rdDrive}, 32'd0);
    readAt(80);
    chk(rdDrive && rdData == model[80], "R12 accepted, data kept", rdData, model[80]);
    readAt(5);
    chk(rdDrive && rdData == model[5], "R12 retention", rdData, model[5]);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule